// File: doc/BRIEF.md
# Interrupt Cause Register with Masked Output

This block keeps the interrupt causes of a storage adapter and turns them into an interrupt request for the host. There are two cause bits. The completion cause is set when the adapter finishes work. The message cause is set when the adapter posts an asynchronous notice. Software clears causes by writing ones to the status register. It selects which causes may interrupt through a separate enable register. Both registers sit on a simple 32-bit register bus that uses word addresses.

The request leaves the block in one of two forms. In legacy mode it is a level that follows the masked causes. In message mode it is a one-cycle notification pulse, sent whenever an update leaves the masked causes nonzero. Message mode needs two inputs to be high: the capability input and the enable input. Each status write is also a natural point to drain more completions. So when the completion queue, seen here only as a "not empty" input, still holds work, a status write raises a one-cycle drain request. An adapter-level reset input clears the causes and keeps the enable mask.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A write to the status register (word address 0) clears every cause bit whose position is set in the write data. Cause bits written with zero keep their value.
- R2: A write to the enable register (word address 1) replaces all 32 bits. A read of address 1 returns exactly the value last written.
- R3: In legacy mode, irq_level equals the OR of (enable bits 1:0 AND status), one clock after the register change. In message mode, irq_level stays 0.
- R4: In message mode, irq_pulse is high for one cycle, one clock after an update, when the masked causes are nonzero after that update. An update is a status write, an enable write, a cause event or an adapter reset. Nothing is sent when the masked causes are zero, and nothing is sent in a cycle without an update.
- R5: cmpl_evt sets status bit 0 (the completion cause). msg_evt sets status bit 1 (the message cause).
- R6: When a cause event and a status write that clears the same bit arrive in the same cycle, the event wins and the bit ends up set.
- R7: drain_req is high for one cycle, one clock after a status write, when cmpl_pending is high during that write. A status write with cmpl_pending low gives no drain request.
- R8: adapter_reset clears the status register and leaves the enable register unchanged. It overrides cause events in the same cycle.
- R9: After power-on reset (rst_n low), status and enable read 0 and irq_level, irq_pulse and drain_req are 0.
- R10: Message mode is active only when msi_capable and msi_enabled are both 1. Otherwise the block is in legacy mode.
- R11: Reads of any address other than 0 or 1 return 0. Writes to such addresses change neither register.
- R12: Status reads return the two cause bits in bits 1:0 and zero in bits 31:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| adapter_reset | input | 1 | Synchronous adapter reset; clears causes only |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| cmpl_evt | input | 1 | Completion event, sets the completion cause |
| msg_evt | input | 1 | Message event, sets the message cause |
| cmpl_pending | input | 1 | Completion queue not empty |
| msi_capable | input | 1 | Message-signalled capability present |
| msi_enabled | input | 1 | Message-signalled delivery enabled by software |
| irq_level | output | 1 | Legacy level interrupt |
| irq_pulse | output | 1 | One-cycle message notification |
| drain_req | output | 1 | One-cycle request to drain pending completions |

## Verification
A corrupted cause or enable bit shows up at the ports in two ways. The register read of that bit is wrong at once. In legacy mode, irq_level is also wrong one clock after the fault. In message mode, a wrong masked condition shows up only at the next update: a pulse is missing or an extra pulse appears. So the bench follows each stimulus with a register read and with an output check exactly one clock later. A mode-select fault shows up as a level appearing where a pulse was due, one clock after the first update in the wrong mode.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_STAT = 2'd1,
        RSEL_EN   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     wr_stat;
        logic     wr_en;
        reg_sel_e rsel;
    } dec_t;

endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
    import irq_cause_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);

    always_comb begin
        dec = '{wr_stat: 1'b0, wr_en: 1'b0, rsel: RSEL_NONE};
        if (bus_addr == STAT_A) begin
            dec.rsel    = RSEL_STAT;
            dec.wr_stat = bus_wr;
        end else if (bus_addr == EN_A) begin
            dec.rsel  = RSEL_EN;
            dec.wr_en = bus_wr;
        end
    end

endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
    import irq_cause_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CAUSE_W  = 2,
    parameter int CMPL_BIT = 0,
    parameter int MSG_BIT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adapter_reset,
    input  dec_t               dec,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               cmpl_evt,
    input  logic               msg_evt,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [CAUSE_W-1:0] stat_q,
    output logic [DATA_W-1:0]  en_q,
    output logic               cond_d,
    output logic               upd
);
    localparam int PAD_W = DATA_W - CAUSE_W;

    typedef struct packed {
        logic [CAUSE_W-1:0] stat;
        logic [DATA_W-1:0]  en;
    } regs_t;

    regs_t r_d, r_q;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[CMPL_BIT] = cmpl_evt;
        set_vec[MSG_BIT]  = set_vec[MSG_BIT] | msg_evt;
        clr_vec = dec.wr_stat ? bus_wdata[CAUSE_W-1:0] : '0;

        r_d = r_q;
        if (dec.wr_en) begin
            r_d.en = bus_wdata;
        end
        if (adapter_reset) begin
            r_d.stat = '0;
        end else begin
            r_d.stat = (r_q.stat & ~clr_vec) | set_vec;
        end

        cond_d = |(r_d.en[CAUSE_W-1:0] & r_d.stat);
        upd    = dec.wr_stat | dec.wr_en | (|set_vec) | adapter_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (dec.rsel)
            RSEL_STAT: bus_rdata = {{PAD_W{1'b0}}, r_q.stat};
            RSEL_EN:   bus_rdata = r_q.en;
            default:   bus_rdata = '0;
        endcase
    end

    assign stat_q = r_q.stat;
    assign en_q   = r_q.en;

endmodule

// File: rtl/irq_cause_out.sv
module irq_cause_out (
    input  logic clk,
    input  logic rst_n,
    input  logic msi_capable,
    input  logic msi_enabled,
    input  logic cond_d,
    input  logic upd,
    input  logic wr_stat,
    input  logic cmpl_pending,
    output logic irq_level,
    output logic irq_pulse,
    output logic drain_req
);
    typedef struct packed {
        logic level;
        logic pulse;
        logic drain;
    } out_t;

    out_t o_d, o_q;
    logic msg_mode;

    always_comb begin
        msg_mode = msi_capable & msi_enabled;
        o_d.level = cond_d & ~msg_mode;
        o_d.pulse = cond_d & msg_mode & upd;
        o_d.drain = wr_stat & cmpl_pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_level = o_q.level;
    assign irq_pulse = o_q.pulse;
    assign drain_req = o_q.drain;

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cause_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CAUSE_W   = 2,
    parameter int CMPL_BIT  = 0,
    parameter int MSG_BIT   = 1,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adapter_reset,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmpl_evt,
    input  logic              msg_evt,
    input  logic              cmpl_pending,
    input  logic              msi_capable,
    input  logic              msi_enabled,
    output logic              irq_level,
    output logic              irq_pulse,
    output logic              drain_req
);
    dec_t               dec;
    logic [CAUSE_W-1:0] stat_q;
    logic [DATA_W-1:0]  en_q;
    logic               cond_d;
    logic               upd;

    irq_cause_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .dec(dec)
    );

    irq_cause_regs #(
        .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .adapter_reset(adapter_reset), .dec(dec),
        .bus_wdata(bus_wdata), .cmpl_evt(cmpl_evt), .msg_evt(msg_evt),
        .bus_rdata(bus_rdata), .stat_q(stat_q), .en_q(en_q),
        .cond_d(cond_d), .upd(upd)
    );

    irq_cause_out u_out (
        .clk(clk), .rst_n(rst_n), .msi_capable(msi_capable), .msi_enabled(msi_enabled),
        .cond_d(cond_d), .upd(upd), .wr_stat(dec.wr_stat), .cmpl_pending(cmpl_pending),
        .irq_level(irq_level), .irq_pulse(irq_pulse), .drain_req(drain_req)
    );

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CAUSE_W   = 2,
    parameter int CMPL_BIT  = 0,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adapter_reset,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               cmpl_evt,
    input logic               cmpl_pending,
    input logic               msi_capable,
    input logic               msi_enabled,
    input logic               irq_level,
    input logic               irq_pulse,
    input logic               drain_req,
    input logic [CAUSE_W-1:0] stat_q,
    input logic [DATA_W-1:0]  en_q
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);

    a_r2_enable_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EN_A) |=> (en_q == $past(bus_wdata)));

    a_r3_no_level_in_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> !$past(msi_capable && msi_enabled));

    a_r10_pulse_needs_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(msi_capable && msi_enabled));

    a_r7_drain_after_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> $past(bus_wr && bus_addr == STAT_A && cmpl_pending));

    a_r8_adapter_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_reset |=> (stat_q == '0));

    a_r5_r6_completion_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_evt && !adapter_reset) |=> stat_q[CMPL_BIT]);

endmodule

bind irq_cause_ctrl irq_cause_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .CMPL_BIT(CMPL_BIT),
    .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adapter_reset(adapter_reset), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cmpl_evt(cmpl_evt),
    .cmpl_pending(cmpl_pending), .msi_capable(msi_capable), .msi_enabled(msi_enabled),
    .irq_level(irq_level), .irq_pulse(irq_pulse), .drain_req(drain_req),
    .stat_q(stat_q), .en_q(en_q)
);

// File: tb/test_irq_cause_ctrl.sv
`timescale 1ns/1ps
module test_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adapter_reset = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmpl_evt = 1'b0;
    logic        msg_evt = 1'b0;
    logic        cmpl_pending = 1'b0;
    logic        msi_capable = 1'b0;
    logic        msi_enabled = 1'b0;
    logic        irq_level, irq_pulse, drain_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_STAT = 4'd0;
    localparam logic [3:0] A_EN   = 4'd1;

    always #4 clk = ~clk;

    irq_cause_ctrl i_irq_cause_ctrl (
        .clk(clk), .rst_n(rst_n), .adapter_reset(adapter_reset), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmpl_evt(cmpl_evt), .msg_evt(msg_evt), .cmpl_pending(cmpl_pending),
        .msi_capable(msi_capable), .msi_enabled(msi_enabled),
        .irq_level(irq_level), .irq_pulse(irq_pulse), .drain_req(drain_req)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; the result is visible at the next one.
    task automatic cycle(logic wr, logic [3:0] a, logic [31:0] d, logic ce, logic me, logic ar);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        cmpl_evt = ce; msg_evt = me; adapter_reset = ar;
        @(negedge clk);
        bus_wr = 1'b0; cmpl_evt = 1'b0; msg_evt = 1'b0; adapter_reset = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v); check("R9 status after reset", v, 0);
        rd(A_EN, v);   check("R9 enable after reset", v, 0);
        check("R9 outputs after reset", {29'd0, irq_level, irq_pulse, drain_req}, 0);
    endtask

    task automatic t_cause_set();
        logic [31:0] v;
        msi_capable = 1'b1; msi_enabled = 1'b0;   // R10: capability alone keeps legacy mode
        cycle(1, A_EN, 32'h3, 0, 0, 0);
        check("R3 level low with no cause", irq_level, 0);
        cycle(0, A_STAT, 0, 1, 0, 0);
        rd(A_STAT, v); check("R5 completion sets bit0", v, 32'h1);
        check("R3 level follows cause", irq_level, 1);
        check("R10 no pulse in legacy mode", irq_pulse, 0);
        cycle(0, A_STAT, 0, 0, 1, 0);
        rd(A_STAT, v); check("R5 message sets bit1", v, 32'h3);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        cmpl_pending = 1'b1;
        cycle(1, A_STAT, 32'h1, 0, 0, 0);
        rd(A_STAT, v); check("R1 clear bit0 only", v, 32'h2);
        check("R7 drain after status write", drain_req, 1);
        @(negedge clk);
        check("R7 drain is one cycle", drain_req, 0);
        cmpl_pending = 1'b0;
        cycle(1, A_STAT, 32'h0, 0, 0, 0);
        rd(A_STAT, v); check("R1 zero write keeps bits", v, 32'h2);
        check("R7 no drain with empty queue", drain_req, 0);
        cycle(1, A_STAT, 32'h2, 0, 0, 0);
        rd(A_STAT, v); check("R1 clear bit1", v, 32'h0);
        check("R3 level drops after clear", irq_level, 0);
    endtask

    task automatic t_enable_replace();
        logic [31:0] v;
        cycle(1, A_EN, 32'hA5A5_0002, 0, 0, 0);
        rd(A_EN, v); check("R2 enable readback", v, 32'hA5A5_0002);
        cycle(0, A_STAT, 0, 0, 1, 0);
        check("R3 level on enabled message cause", irq_level, 1);
        cycle(1, A_EN, 32'hFFFF_FFFD, 0, 0, 0);
        rd(A_EN, v); check("R2 enable fully replaced", v, 32'hFFFF_FFFD);
        check("R3 level off when masked", irq_level, 0);
        cycle(1, A_STAT, 32'hFFFF_FFFF, 1, 0, 0);
        rd(A_STAT, v); check("R6 event beats clear; R12 upper bits zero", v, 32'h1);
        check("R3 level on completion", irq_level, 1);
        cycle(1, A_STAT, 32'h1, 0, 0, 0);
    endtask

    task automatic t_msg_mode();
        logic [31:0] v;
        msi_capable = 1'b1; msi_enabled = 1'b1;
        cycle(1, A_EN, 32'h1, 0, 0, 0);
        check("R4 no pulse when condition false", irq_pulse, 0);
        cycle(0, A_STAT, 0, 1, 0, 0);
        check("R4 pulse after completion", irq_pulse, 1);
        check("R3 level held low in message mode", irq_level, 0);
        @(negedge clk);
        check("R4 no pulse without update", irq_pulse, 0);
        cycle(1, A_EN, 32'h1, 0, 0, 0);
        check("R4 pulse after enable rewrite", irq_pulse, 1);
        cycle(1, A_EN, 32'h0, 0, 0, 0);
        check("R4 no pulse after masking", irq_pulse, 0);
        cycle(0, A_STAT, 0, 0, 1, 0);
        check("R4 no pulse for masked message", irq_pulse, 0);
        msi_capable = 1'b0;
        cycle(1, A_EN, 32'h2, 0, 0, 0);
        check("R10 enable without capability is legacy", {30'd0, irq_level, irq_pulse}, 32'h2);
        rd(A_STAT, v); check("R5 both causes held", v, 32'h3);
    endtask

    task automatic t_adapter_reset();
        logic [31:0] v;
        cycle(0, A_STAT, 0, 1, 1, 1);
        rd(A_STAT, v); check("R8 status cleared over events", v, 0);
        rd(A_EN, v);   check("R8 enable kept", v, 32'h2);
        check("R8 level low after adapter reset", irq_level, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        cycle(0, A_STAT, 0, 0, 1, 0);
        cycle(1, 4'd5, 32'hFFFF_FFFF, 0, 0, 0);
        rd(A_STAT, v); check("R11 unmapped write leaves status", v, 32'h2);
        rd(A_EN, v);   check("R11 unmapped write leaves enable", v, 32'h2);
        rd(4'd5, v);   check("R11 unmapped read is zero", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cause_set();
        t_w1c();
        t_enable_replace();
        t_msg_mode();
        t_adapter_reset();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule